// File: doc/BRIEF.md
# Indirect Byte-Register Window

This block lets a 32-bit memory-mapped port reach a bank of 256 byte-wide registers that sit behind a slower core. One 32-bit write carries a whole command: the byte address, the byte to store and a direction bit. After the write is accepted, a busy flag in the same word goes high for a fixed number of core cycles, `LAT`. When busy drops, the command has taken effect.

A write command stores its byte into the bank at that moment. A read command instead loads the addressed byte into the top byte of the window word. Software posts a command, polls the busy flag until it clears, and then takes the result from bits [31:24]. The lower fields of the window word echo the last accepted command. Commands that arrive while busy is high are dropped. The bank is cleared at reset.

Top module: `byte_window_bridge`

## Requirements
- R1: After reset the window word reads 0 and every bank byte reads back as 0.
- R2: The window word carries the command and its result in fixed fields. Bits [7:0] hold the byte address, bits [15:8] hold the write byte, and bit 16 is the direction (1 = write, 0 = read). These fields echo the last accepted command from the edge that accepts it.
- R3: The window word reports the busy flag in bit 23. An accepted command drives it high from the next cycle, and it stays high for exactly `LAT` cycles.
- R4: A window write presented while busy is high is ignored. The command fields, the busy timing and the bank are all left unchanged.
- R5: A write command stores its byte into the bank at the addressed location in the edge where busy clears. It leaves bits [31:24] unchanged.
- R6: A read command loads the addressed bank byte into bits [31:24] in the edge where busy clears. Those bits hold still while busy is high.
- R7: Bits [22:17] of the window word always read 0.
- R8: A window write that coincides with the edge that clears busy is ignored. A write in the very next cycle is accepted.
- R9: All 256 byte addresses are distinct, including 0x00 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_wr | input | 1 | Window write strobe, one cycle per command |
| win_wdata | input | 32 | Window write word: address [7:0], byte [15:8], direction [16] |
| win_rdata | output | 32 | Window read word: command echo, busy [23], result byte [31:24] |

## Verification
The risky overlap is a new window write landing on the same edge as the completion of the command in flight. In that edge the bridge could either drop the new command or start it. The bench provokes this by counting `LAT` cycles from acceptance and raising the strobe during the last busy cycle. It judges the outcome by reading the target address afterwards and by comparing the whole window word against a behavioural model on every cycle. The same model also covers a strobe raised in the cycle right after busy falls, which must be taken.

// File: rtl/byte_window_bridge.sv
module byte_window_bridge #(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        win_wr,
  input  logic [31:0] win_wdata,
  output logic [31:0] win_rdata
);
  localparam int DEPTH = 256;
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

  logic [7:0]    bank [DEPTH];
  logic [7:0]    c_addr, c_data, rd_byte;
  logic          c_wr, busy;
  logic [CW-1:0] left;

  wire accept = win_wr && !busy;
  wire finish = busy && (left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_addr  <= '0;
      c_data  <= '0;
      c_wr    <= 1'b0;
      busy    <= 1'b0;
      left    <= '0;
      rd_byte <= '0;
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (accept) begin
      c_addr <= win_wdata[7:0];
      c_data <= win_wdata[15:8];
      c_wr   <= win_wdata[16];
      busy   <= 1'b1;
      left   <= CW'(LAT - 1);
    end else if (finish) begin
      busy <= 1'b0;
      if (c_wr) bank[c_addr] <= c_data;
      else      rd_byte      <= bank[c_addr];
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end

  assign win_rdata = {rd_byte, busy, 6'b0, c_wr, c_data, c_addr};
endmodule

module byte_window_bridge_chk #(
  parameter int LAT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        win_wr,
  input logic [31:0] win_wdata,
  input logic [31:0] win_rdata
);
  wire busy = win_rdata[23];
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  a_r3_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !busy) |=> busy);

  a_r3_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(LAT));

  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(win_rdata[16:0]));

  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(win_rdata[31:24]));

  a_r5_write_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && win_rdata[16]) |-> $stable(win_rdata[31:24]));

  a_r7_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
    win_rdata[22:17] == 6'b0);
endmodule

bind byte_window_bridge byte_window_bridge_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_wr(win_wr),
  .win_wdata(win_wdata), .win_rdata(win_rdata)
);

// File: tb/byte_window_bridge_bench.sv
module byte_window_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_wr = 1'b0;
  logic [31:0] win_wdata = '0;
  logic [31:0] win_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  byte_window_bridge #(.LAT(LAT)) u_byte_window_bridge (
    .clk(clk), .rst_n(rst_n), .win_wr(win_wr),
    .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  byte m_bank [256];
  int  m_left = 0;
  int  m_addr = 0, m_data = 0, m_dir = 0, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bank[i]) m_bank[i] = 0;
      m_left = 0; m_addr = 0; m_data = 0; m_dir = 0; m_rd = 0;
    end else if (m_left > 0) begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        if (m_dir == 1) m_bank[m_addr] = byte'(m_data);
        else            m_rd = int'(m_bank[m_addr]) & 8'hFF;
      end
    end else if (win_wr) begin
      m_addr = int'(win_wdata[7:0]);
      m_data = int'(win_wdata[15:8]);
      m_dir  = int'(win_wdata[16]);
      m_left = LAT;
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = '0;
    w[7:0]   = 8'(m_addr);
    w[15:8]  = 8'(m_data);
    w[16]    = m_dir[0];
    w[23]    = (m_left > 0);
    w[31:24] = 8'(m_rd);
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // cycle compare against the model (R2 field layout)
  always @(negedge clk) begin
    if (rst_n && !done) check("R2 model", win_rdata, model_word());
  end

  task automatic post(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    win_wr = 1'b1;
    win_wdata = {15'b0, wr, d, a};
    @(negedge clk);
    win_wr = 1'b0;
    win_wdata = '0;
  endtask

  task automatic wait_idle();
    while (win_rdata[23]) @(negedge clk);
  endtask

  task automatic read_byte(input logic [7:0] a, output logic [7:0] v);
    post(1'b0, a, 8'h00);
    wait_idle();
    v = win_rdata[31:24];
  endtask

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 reset word", win_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R5: write, count busy cycles, result byte untouched
    post(1'b1, 8'h10, 8'hA5);
    check("R3 busy next cycle", {31'b0, win_rdata[23]}, 32'h1);
    cnt = 0;
    while (win_rdata[23]) begin cnt++; @(negedge clk); end
    check("R3 busy length", cnt, LAT);
    check("R5 result unchanged", {24'b0, win_rdata[31:24]}, 32'h0);
    check("R2 echo", win_rdata[16:0], {1'b1, 8'hA5, 8'h10});
    check("R7 gap", {26'b0, win_rdata[22:17]}, 32'h0);

    // R6 read back
    read_byte(8'h10, v);
    check("R6 read byte", {24'b0, v}, 32'h0000_00A5);
    read_byte(8'h11, v);
    check("R1 bank cleared", {24'b0, v}, 32'h0);

    // R4 write while busy
    post(1'b1, 8'h20, 8'h11);
    @(negedge clk);
    win_wr = 1'b1; win_wdata = {15'b0, 1'b1, 8'h22, 8'h21};
    @(negedge clk);
    win_wr = 1'b0; win_wdata = '0;
    check("R4 fields kept", win_rdata[16:0], {1'b1, 8'h11, 8'h20});
    wait_idle();
    read_byte(8'h21, v);
    check("R4 bank untouched", {24'b0, v}, 32'h0);
    read_byte(8'h20, v);
    check("R5 first write landed", {24'b0, v}, 32'h0000_0011);

    // R8 strobe on the completing edge, then right after
    post(1'b0, 8'h20, 8'h00);
    repeat (LAT - 1) @(negedge clk);
    win_wr = 1'b1; win_wdata = {15'b0, 1'b1, 8'h33, 8'h30};
    @(negedge clk);
    check("R8 busy cleared", {31'b0, win_rdata[23]}, 32'h0);
    check("R8 collision dropped", win_rdata[16:0], {1'b0, 8'h00, 8'h20});
    win_wdata = {15'b0, 1'b1, 8'h44, 8'h31};
    @(negedge clk);
    win_wr = 1'b0; win_wdata = '0;
    check("R8 next accepted", {31'b0, win_rdata[23]}, 32'h1);
    wait_idle();
    read_byte(8'h30, v);
    check("R8 dropped no store", {24'b0, v}, 32'h0);
    read_byte(8'h31, v);
    check("R8 accepted store", {24'b0, v}, 32'h0000_0044);

    // R9 address extremes
    post(1'b1, 8'hFF, 8'h5A); wait_idle();
    post(1'b1, 8'h00, 8'hC3); wait_idle();
    read_byte(8'hFF, v);
    check("R9 top address", {24'b0, v}, 32'h0000_005A);
    read_byte(8'h00, v);
    check("R9 bottom address", {24'b0, v}, 32'h0000_00C3);
    read_byte(8'h7F, v);
    check("R9 middle untouched", {24'b0, v}, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule